// File: doc/BRIEF.md
# Butterfly Multiply, Add/Subtract and Rounding Shift Unit

This block performs one integer butterfly step of a fixed-point FFT or DCT kernel. A single signed multiplication of two operands is formed and truncated to the data width. That truncated product is added to one accumulator input (T) and subtracted from a second accumulator input (S) in the same step, so both halves of the butterfly leave together.

Each of the two results may then be scaled down by a shift amount `n`. When `n` is non-zero, half of one output step is added first, giving round-half-up. The rounded value is then shifted right arithmetically. When `n` is zero the raw sums leave unchanged. All arithmetic wraps at the data width, and no flags are produced.

The unit is a two-stage pipeline. It accepts a new operation on every cycle. Stage one registers the product. Stage two registers the two rounded results together with the output valid bit.

Top module: `bfly_round_unit`

## Requirements
- R1: The product is the signed product of `mul_a` and `mul_b` taken modulo 2^XLEN (its low XLEN bits). Example: the most negative value times -1 gives 0x8000_0000_0000_0000, and the most negative value times itself gives 0.
- R2: `res_t` equals `acc_t` plus the product, modulo 2^XLEN, before any rounding.
- R3: `res_s` equals `acc_s` minus the product, modulo 2^XLEN, before any rounding. It is computed from the same inputs as `res_t` and presented in the same cycle.
- R4: When `shamt` is 0, each result is its raw sum, with no rounding constant and no shift.
- R5: When `shamt` = n > 0, each result is (sum + 2^(n-1)) shifted right arithmetically by n, so a value exactly half-way rounds toward plus infinity. For example, with n=1, +1.5 becomes 2 and -1.5 becomes -1. The top n bits of the result all equal its sign bit.
- R6: The sign used for the shift is the MSB after the rounding constant has been added, modulo 2^XLEN. Example: sum 0x7FFF_FFFF_FFFF_FFFF with n=1 gives 0xC000_0000_0000_0000.
- R7: `out_valid` is high exactly two clock cycles after `in_valid` was high. An active-low synchronous reset clears both pipeline valid bits.
- R8: `in_ready` is always 1. Operations presented on consecutive cycles each produce a result, in order, on consecutive cycles.
- R9: While no valid operation reaches the output stage, `res_t` and `res_s` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_ready | output | 1 | Unit accepts an operation (always 1) |
| mul_a | input | XLEN | Signed multiplier operand |
| mul_b | input | XLEN | Signed multiplicand operand |
| acc_t | input | XLEN | Accumulator that receives the product |
| acc_s | input | XLEN | Accumulator the product is subtracted from |
| shamt | input | SHW | Rounding shift amount n |
| out_valid | output | 1 | Results valid |
| res_t | output | XLEN | Rounded T plus product |
| res_s | output | XLEN | Rounded S minus product |

## Verification
Each path has only one register stage, so every internal fault shows up two cycles after the operation is presented. A wrong rounding constant moves exactly-half-way results by one step; the +1.5 and -1.5 cases catch that. Taking the sign before the rounding add only shows when the rounding carry crosses into the MSB, so one vector is built so that it does. A product kept at the wrong width, or swapped add/subtract paths, corrupt the most-negative and wrap-around vectors. Pipeline-valid faults show up during back-to-back streaming and during hold periods.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
   typedef enum logic {
      PATH_ADD = 1'b0,
      PATH_SUB = 1'b1
   } bfly_path_e;
endpackage

// File: rtl/bfly_mul_stage.sv
module bfly_mul_stage #(
   parameter int XLEN = 64,
   parameter int SHW  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic [XLEN-1:0] acc_t,
   input  logic [XLEN-1:0] acc_s,
   input  logic [SHW-1:0]  shamt,
   output logic            v_q,
   output logic [XLEN-1:0] prod_q,
   output logic [XLEN-1:0] t_q,
   output logic [XLEN-1:0] s_q,
   output logic [SHW-1:0]  n_q
);
   // Low half of a two's-complement product does not depend on signedness.
   logic [XLEN-1:0] prod_lo;
   assign prod_lo = op_a * op_b;

   always_ff @(posedge clk) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         prod_q <= prod_lo;
         t_q    <= acc_t;
         s_q    <= acc_s;
         n_q    <= shamt;
      end
   end

   // R7
   stage1_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (v_q == $past(in_valid)));
endmodule

// File: rtl/bfly_round_path.sv
module bfly_round_path
   import bfly_pkg::*;
#(
   parameter int         XLEN = 64,
   parameter int         SHW  = 5,
   parameter bfly_path_e PATH = PATH_ADD
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [XLEN-1:0] acc,
   input  logic [XLEN-1:0] prod,
   input  logic [SHW-1:0]  n,
   output logic [XLEN-1:0] res_q
);
   logic [XLEN-1:0] sum, half, rnd, rot, keep, sfill, shaped;
   logic            n_zero;

   generate
      if (PATH == PATH_SUB) begin : g_sub
         assign sum = acc - prod;
      end else begin : g_add
         assign sum = acc + prod;
      end
   endgenerate

   assign n_zero = (n == '0);
   assign half   = n_zero ? '0 : ({{(XLEN-1){1'b0}}, 1'b1} << (n - 1'b1));
   assign rnd    = sum + half;

   // rotate right by n, keep low XLEN-n bits, fill the top with the rounded sign
   assign rot    = (rnd >> n) | (rnd << (XLEN - int'(n)));
   assign keep   = {XLEN{1'b1}} >> n;
   assign sfill  = {XLEN{rnd[XLEN-1]}} & ~keep;
   assign shaped = n_zero ? sum : ((rot & keep) | sfill);

   always_ff @(posedge clk) begin
      if (ld) res_q <= shaped;
   end

   // R4
   n0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && n_zero) |=> (res_q == $past(sum)));
   // R6
   sign_after_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !n_zero) |=> (res_q[XLEN-1] == $past(rnd[XLEN-1])));
   // R5
   sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !n_zero) |=> (((res_q & ~$past(keep)) == '0) ||
                           ((res_q | $past(keep)) == {XLEN{1'b1}})));
   // R9
   hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && $past(rst_n)) |=> $stable(res_q));
endmodule

// File: rtl/bfly_round_unit.sv
module bfly_round_unit
   import bfly_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int SHW  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [XLEN-1:0] mul_a,
   input  logic [XLEN-1:0] mul_b,
   input  logic [XLEN-1:0] acc_t,
   input  logic [XLEN-1:0] acc_s,
   input  logic [SHW-1:0]  shamt,
   output logic            out_valid,
   output logic [XLEN-1:0] res_t,
   output logic [XLEN-1:0] res_s
);
   localparam int NPATH = 2;

   generate
      if (XLEN < 2) begin : g_bad_xlen
         $error("bfly_round_unit: XLEN must be at least 2");
      end
      if ((2 ** SHW) > XLEN) begin : g_bad_shw
         $error("bfly_round_unit: shift range must stay below XLEN");
      end
   endgenerate

   logic            v1;
   logic [XLEN-1:0] prod_q, t_q, s_q;
   logic [SHW-1:0]  n_q;
   logic [XLEN-1:0] res_arr [NPATH];

   assign in_ready = 1'b1;

   bfly_mul_stage #(.XLEN(XLEN), .SHW(SHW)) i_mul (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(mul_a), .op_b(mul_b), .acc_t(acc_t), .acc_s(acc_s), .shamt(shamt),
      .v_q(v1), .prod_q(prod_q), .t_q(t_q), .s_q(s_q), .n_q(n_q)
   );

   generate
      for (genvar g = 0; g < NPATH; g++) begin : g_path
         bfly_round_path #(
            .XLEN(XLEN), .SHW(SHW),
            .PATH((g == 0) ? PATH_ADD : PATH_SUB)
         ) i_path (
            .clk(clk), .rst_n(rst_n), .ld(v1),
            .acc((g == 0) ? t_q : s_q),
            .prod(prod_q), .n(n_q),
            .res_q(res_arr[g])
         );
      end
   endgenerate

   assign res_t = res_arr[0];
   assign res_s = res_arr[1];

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= v1;
   end

   // R7
   out_valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(v1)));
endmodule

// File: tb/test_bfly_round_unit.sv
module test_bfly_round_unit;
   localparam int XLEN = 64;
   localparam int SHW  = 5;
   localparam int NSTREAM = 40;

   typedef struct packed {
      logic [XLEN-1:0] a, b, t, s;
      logic [SHW-1:0]  n;
      logic [XLEN-1:0] et, es;
   } vec_t;

   localparam logic [XLEN-1:0] MINV = 64'h8000_0000_0000_0000;
   localparam logic [XLEN-1:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

   localparam vec_t VTAB [8] = '{
      '{64'd3, 64'd5, 64'd10, 64'd100, 5'd0, 64'd25, 64'd85},
      '{64'd1, 64'd3, 64'd0, 64'd0, 5'd1, 64'd2, ONES},
      '{64'd1, 64'h4000_0000, 64'd0, 64'd0, 5'd31, 64'd1, 64'd0},
      '{64'd0, 64'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 5'd1, 64'hC000_0000_0000_0000, 64'd0},
      '{MINV, MINV, 64'd7, 64'd7, 5'd0, 64'd7, 64'd7},
      '{MINV, ONES, 64'd0, 64'd0, 5'd0, MINV, MINV},
      '{ONES, 64'd6, 64'd0, 64'd0, 5'd2, ONES, 64'd2},
      '{64'd2, 64'h4000_0000_0000_0000, 64'd0, 64'd1, 5'd0, MINV, 64'h8000_0000_0000_0001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready, out_valid;
   logic [XLEN-1:0] mul_a = '0, mul_b = '0, acc_t = '0, acc_s = '0;
   logic [SHW-1:0]  shamt = '0;
   logic [XLEN-1:0] res_t, res_s;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   bfly_round_unit #(.XLEN(XLEN), .SHW(SHW)) i_bfly_round_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .mul_a(mul_a), .mul_b(mul_b), .acc_t(acc_t), .acc_s(acc_s), .shamt(shamt),
      .out_valid(out_valid), .res_t(res_t), .res_s(res_s)
   );

   function automatic logic [XLEN-1:0] ref_calc(input logic [XLEN-1:0] acc, a, b,
                                                 input bit sub, input logic [SHW-1:0] n);
      logic signed [2*XLEN-1:0] fp;
      logic [XLEN-1:0] sm;
      fp = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});
      sm = sub ? (acc - fp[XLEN-1:0]) : (acc + fp[XLEN-1:0]);
      if (n == 0) return sm;
      sm = sm + (64'd1 << (n - 1));
      return XLEN'($signed(sm) >>> n);
   endfunction

   task automatic chk(input string req, input logic [XLEN-1:0] act, exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v, input logic vld);
      in_valid = vld; mul_a = v.a; mul_b = v.b; acc_t = v.t; acc_s = v.s; shamt = v.n;
   endtask

   logic [XLEN-1:0] x = 64'h1234_5678_9ABC_DEF1;
   function automatic logic [XLEN-1:0] nxt(input logic [XLEN-1:0] v);
      logic [XLEN-1:0] r;
      r = v ^ (v << 13); r = r ^ (r >> 7); r = r ^ (r << 17);
      return r;
   endfunction

   vec_t sv [NSTREAM];

   initial begin : watchdog
      #(5 * 20000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state
      chk("R7 reset valid", {63'd0, out_valid}, 64'd0);
      chk("R8 ready", {63'd0, in_ready}, 64'd1);
      rst_n = 1'b1;

      // directed table: R1 R2 R3 R4 R5 R6
      foreach (VTAB[i]) begin
         @(negedge clk); drive(VTAB[i], 1'b1);
         @(negedge clk); drive(VTAB[i], 1'b0);
         chk("R7 not early", {63'd0, out_valid}, 64'd0);
         @(negedge clk);
         chk("R7 valid", {63'd0, out_valid}, 64'd1);
         chk($sformatf("R2 R4 R5 R6 vec%0d t", i), res_t, VTAB[i].et);
         chk($sformatf("R1 R3 R5 vec%0d s", i), res_s, VTAB[i].es);
      end

      // R9: hold with idle, changing inputs
      @(negedge clk);
      drive('{64'd9, 64'd9, 64'd9, 64'd9, 5'd3, 64'd0, 64'd0}, 1'b0);
      repeat (3) @(negedge clk);
      chk("R9 hold t", res_t, VTAB[7].et);
      chk("R9 hold s", res_s, VTAB[7].es);
      chk("R9 idle valid", {63'd0, out_valid}, 64'd0);

      // R8: back-to-back stream against model
      for (int i = 0; i < NSTREAM; i++) begin
         x = nxt(x); sv[i].a = x;
         x = nxt(x); sv[i].b = (i % 3 == 0) ? {{48{x[15]}}, x[15:0]} : x;
         x = nxt(x); sv[i].t = x;
         x = nxt(x); sv[i].s = x;
         sv[i].n = (i < 3) ? SHW'(i * 15 + ((i == 2) ? 1 : 0)) : x[SHW-1:0];
         sv[i].et = ref_calc(sv[i].t, sv[i].a, sv[i].b, 1'b0, sv[i].n);
         sv[i].es = ref_calc(sv[i].s, sv[i].a, sv[i].b, 1'b1, sv[i].n);
      end
      for (int k = 0; k < NSTREAM + 2; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            chk("R8 stream valid", {63'd0, out_valid}, 64'd1);
            chk("R2 R5 stream t", res_t, sv[k-2].et);
            chk("R3 R5 stream s", res_s, sv[k-2].es);
         end
         if (k < NSTREAM) drive(sv[k], 1'b1);
         else             drive(sv[0], 1'b0);
      end
      @(negedge clk);
      chk("R7 drain", {63'd0, out_valid}, 64'd0);

      // R7: reset clears in-flight valids
      drive(VTAB[0], 1'b1);
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      chk("R7 reset flush", {63'd0, out_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 after reset", {63'd0, out_valid}, 64'd0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule